// File: doc/BRIEF.md
# Set-Bit Isolation Serializer

This block accepts a 32-bit word and returns its set bits one at a time. Each output is a one-hot word that holds exactly one bit of the input. The outputs come from the least significant set bit upwards. A working register holds the bits not yet emitted. Each step applies two identities to that register. The first is the lowest-one isolate, `x & -x`, which gives the output word. The second is the lowest-one clear, `x & (x - 1)`, which gives the next working value. Because of this, a word with k set bits needs k output beats, not one step per bit position.

A user waits for `idle_o`, then pulses `start_i` with the word on `word_i`. Output beats use a valid/ready handshake. `done_o` pulses once after the last beat is accepted, and `count_o` then holds the number of beats, which equals the population count of the input. The isolate can be built in either of two equivalent forms, chosen by a parameter: `x & -x` or `x ^ (x & (x - 1))`.

Top module: `setbit_serializer`

## Requirements
- R1: After reset, `idle_o` is 1, `valid_o` and `done_o` are 0, and `count_o` is 0.
- R2: While `valid_o` is 1, `bit_o` has exactly one bit set. That bit is the lowest set bit among the input bits not yet accepted.
- R3: Beats come in strictly ascending bit order and cover every set bit of the input exactly once. For example, input 2019 gives 1, 2, 32, 64, 128, 256, 512, 1024, and input 0x64 gives 0x04, 0x20, 0x40.
- R4: `count_o` rises by one for each accepted beat (`valid_o` and `ready_i` both 1 at a rising edge). At `done_o`, it equals the population count of the input. It is 6 bits wide, so it can show 32.
- R5: While `valid_o` is 1 and `ready_i` is 0, `valid_o` and `bit_o` keep their values.
- R6: `done_o` is 1 for exactly one cycle, the cycle after the last beat is accepted. It is never 1 in the same cycle as `valid_o`.
- R7: A zero input produces no beats. `done_o` is 1 in the cycle after the start, and `count_o` is 0.
- R8: While `idle_o` is 0, `start_i` and `word_i` are ignored. The beats of the serialization already running are not affected.
- R9: When `idle_o` is 1 and `start_i` is 1, the word is captured at that edge. The first beat appears in the next cycle, and `idle_o` returns to 1 in the cycle after `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request to begin; acted on only while idle |
| word_i | input | 32 | Word to break into single bits |
| idle_o | output | 1 | Unit can take a new word |
| valid_o | output | 1 | `bit_o` holds a beat |
| ready_i | input | 1 | Consumer takes the current beat |
| bit_o | output | 32 | One-hot beat |
| done_o | output | 1 | One-cycle pulse after the final beat |
| count_o | output | 6 | Beats accepted for the current word |

## Verification
The hardest case to reach is a start request that arrives while a beat is stalled. This must leave the running sequence intact (R8), and at the same time the held beat must stay stable (R5). The stimulus reaches it on purpose: during stalls it raises `start_i` with the complement of the running word. It then checks that every later beat still follows the original word. Random back-pressure also lands stalls on first beats, on last beats and on the all-ones word, where the count reaches 32.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    localparam int unsigned SBS_DATA_W = 32;
    localparam int unsigned SBS_CNT_W  = $clog2(SBS_DATA_W + 1);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EMIT = 2'd1,
        ST_FIN  = 2'd2
    } sbs_state_e;

    typedef enum logic {
        ISO_NEGATE = 1'b0,
        ISO_XOR    = 1'b1
    } sbs_iso_form_e;

endpackage

// File: rtl/sbs_isolate.sv
module sbs_isolate
    import sbs_pkg::*;
#(
    parameter int unsigned   W    = SBS_DATA_W,
    parameter sbs_iso_form_e FORM = ISO_NEGATE
) (
    input  logic [W-1:0] work_i,
    output logic [W-1:0] low_o,
    output logic [W-1:0] rest_o,
    output logic         rest_zero_o
);

    logic [W-1:0] minus_one;

    assign minus_one = work_i - W'(1);
    assign rest_o    = work_i & minus_one;
    assign rest_zero_o = (rest_o == '0);

    generate
        if (FORM == ISO_XOR) begin : g_xor
            assign low_o = work_i ^ rest_o;
        end else begin : g_neg
            assign low_o = work_i & (~work_i + W'(1));
        end
    endgenerate

endmodule

// File: rtl/sbs_fsm.sv
module sbs_fsm
    import sbs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       in_zero_i,
    input  logic       ready_i,
    input  logic       rest_zero_i,
    output sbs_state_e state_o,
    output logic       load_o,
    output logic       take_o
);

    sbs_state_e state_q, state_d;

    assign load_o = (state_q == ST_IDLE) && start_i;
    assign take_o = (state_q == ST_EMIT) && ready_i;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: if (start_i) state_d = in_zero_i ? ST_FIN : ST_EMIT;
            ST_EMIT: if (ready_i && rest_zero_i) state_d = ST_FIN;
            ST_FIN:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign state_o = state_q;

endmodule

// File: rtl/sbs_tally.sv
module sbs_tally #(
    parameter int unsigned CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear_i,
    input  logic             step_i,
    output logic [CNT_W-1:0] count_o
);

    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst || clear_i) count_q <= '0;
        else if (step_i)    count_q <= count_q + CNT_W'(1);
    end

    assign count_o = count_q;

endmodule

// File: rtl/setbit_serializer.sv
module setbit_serializer
    import sbs_pkg::*;
#(
    parameter int unsigned   W     = SBS_DATA_W,
    parameter int unsigned   CNT_W = $clog2(W + 1),
    parameter sbs_iso_form_e FORM  = ISO_NEGATE
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [W-1:0]     word_i,
    output logic             idle_o,
    output logic             valid_o,
    input  logic             ready_i,
    output logic [W-1:0]     bit_o,
    output logic             done_o,
    output logic [CNT_W-1:0] count_o
);

    sbs_state_e   state;
    logic         load, take;
    logic [W-1:0] work_q, low_bit, rest;
    logic         rest_zero;

    sbs_isolate #(.W(W), .FORM(FORM)) u_iso (
        .work_i      (work_q),
        .low_o       (low_bit),
        .rest_o      (rest),
        .rest_zero_o (rest_zero)
    );

    sbs_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .in_zero_i   (word_i == '0),
        .ready_i     (ready_i),
        .rest_zero_i (rest_zero),
        .state_o     (state),
        .load_o      (load),
        .take_o      (take)
    );

    sbs_tally #(.CNT_W(CNT_W)) u_tally (
        .clk     (clk),
        .rst     (rst),
        .clear_i (load),
        .step_i  (take),
        .count_o (count_o)
    );

    always_ff @(posedge clk) begin
        if (rst)       work_q <= '0;
        else if (load) work_q <= word_i;
        else if (take) work_q <= rest;
    end

    assign idle_o  = (state == ST_IDLE);
    assign valid_o = (state == ST_EMIT);
    assign done_o  = (state == ST_FIN);
    assign bit_o   = valid_o ? low_bit : '0;

endmodule

// File: rtl/sbs_checker.sv
module sbs_checker #(
    parameter int unsigned W     = 32,
    parameter int unsigned CNT_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic             idle_o,
    input logic             valid_o,
    input logic             ready_i,
    input logic [W-1:0]     bit_o,
    input logic             done_o,
    input logic [CNT_W-1:0] count_o
);

    AST_BEAT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> ($countones(bit_o) == 1)); // R2

    AST_ASCENDING: assert property (@(posedge clk) disable iff (rst)
        (valid_o && ready_i) |=> (!valid_o || (bit_o > $past(bit_o)))); // R3

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (valid_o && ready_i) |=> (count_o == $past(count_o) + CNT_W'(1))); // R4

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !ready_i) |=> (valid_o && $stable(bit_o))); // R5

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R6

    AST_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(done_o && valid_o)); // R6

    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !ready_i && start_i) |=> valid_o); // R8

    AST_START_TAKE: assert property (@(posedge clk) disable iff (rst)
        (idle_o && start_i) |=> !idle_o); // R9

endmodule

bind setbit_serializer sbs_checker #(.W(W), .CNT_W(CNT_W)) u_sbs_checker (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .idle_o  (idle_o),
    .valid_o (valid_o),
    .ready_i (ready_i),
    .bit_o   (bit_o),
    .done_o  (done_o),
    .count_o (count_o)
);

// File: tb/test_setbit_serializer.sv
module test_setbit_serializer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [31:0] word_i = '0;
    logic        ready_i = 1'b0;
    logic        idle_o, valid_o, done_o;
    logic [31:0] bit_o;
    logic [5:0]  count_o;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    setbit_serializer i_setbit_serializer (
        .clk(clk), .rst(rst), .start_i(start_i), .word_i(word_i),
        .idle_o(idle_o), .valid_o(valid_o), .ready_i(ready_i),
        .bit_o(bit_o), .done_o(done_o), .count_o(count_o)
    );

    function automatic logic [31:0] lowest(input logic [31:0] x);
        for (int i = 0; i < 32; i++) if (x[i]) return 32'(1) << i;
        return '0;
    endfunction

    function automatic int popc(input logic [31:0] x);
        int n = 0;
        for (int i = 0; i < 32; i++) n += int'(x[i]);
        return n;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // stall_pct: chance of holding ready low; poke: raise start while stalled
    task automatic serialize(input logic [31:0] w, input int stall_pct, input bit poke);
        logic [31:0] rem = w;
        int n = 0;
        chk(idle_o == 1'b1, "R9", idle_o, 1);
        start_i = 1'b1; word_i = w; ready_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0; word_i = '0;
        chk(idle_o == 1'b0, "R9", idle_o, 0);
        for (int g = 0; g < 400; g++) begin
            if (rem == 0) begin
                chk(done_o == 1'b1, (w == 0) ? "R7" : "R6", done_o, 1);
                chk(valid_o == 1'b0, "R6", valid_o, 0);
                chk(int'(count_o) == popc(w), (w == 0) ? "R7" : "R4", count_o, popc(w));
                ready_i = 1'b0;
                @(negedge clk);
                chk(done_o == 1'b0, "R6", done_o, 0);
                chk(idle_o == 1'b1, "R9", idle_o, 1);
                return;
            end
            chk(valid_o == 1'b1, "R2", valid_o, 1);
            chk(bit_o == lowest(rem), (n == 0) ? "R2" : "R3", bit_o, lowest(rem));
            chk(int'(count_o) == n, "R4", count_o, n);
            ready_i = ($urandom % 100) >= stall_pct;
            if (poke && !ready_i) begin
                start_i = 1'b1; word_i = ~w;   // R8: must have no effect
            end
            if (ready_i) begin
                rem = rem & (rem - 1);
                n++;
            end else begin
                @(negedge clk);
                start_i = 1'b0; word_i = '0;
                chk(valid_o && bit_o == lowest(rem), poke ? "R8" : "R5", bit_o, lowest(rem));
                continue;
            end
            @(negedge clk);
            start_i = 1'b0; word_i = '0;
        end
        chk(1'b0, "R6", 0, 1);
    endtask

    initial begin
        #(20 * 150000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd7321));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(idle_o == 1'b1, "R1", idle_o, 1);
        chk(valid_o == 1'b0, "R1", valid_o, 0);
        chk(done_o == 1'b0, "R1", done_o, 0);
        chk(count_o == 6'd0, "R1", count_o, 0);

        serialize(32'd0, 0, 1'b0);            // R7
        serialize(32'd2019, 0, 1'b0);         // R3
        serialize(32'h0000_0064, 50, 1'b0);   // R3, R5
        serialize(32'hFFFF_FFFF, 30, 1'b1);   // R4 count 32, R8
        serialize(32'h8000_0000, 60, 1'b1);   // R8
        serialize(32'h0000_0001, 0, 1'b0);
        for (int k = 0; k < 40; k++) begin
            logic [31:0] w = $urandom;
            if (k % 3 == 0) w = w & $urandom & $urandom;
            serialize(w, int'($urandom % 70), (k % 2) == 1);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule